// File: doc/BRIEF.md
# Compartment Segment Write Guard and Controller-Set Router

This block sits on the memory request path of one processor compartment. The global address space is the same for every compartment and is cut into equal segments, one for each compartment. The upper address bits name the segment. The compartment may read every segment but may write only the segment whose index equals its own static identifier. A refused write is answered with an error status and never reaches memory.

Each accepted request is translated into a physical address inside a memory controller set. That address is a fixed set base plus the segment index times the segment size plus the offset. The request is then sent to one of two redundant controller sets. While both sets are healthy, one address bit spreads the traffic across them. When one set is flagged as failed, all traffic goes to the other set with no reset. When both are flagged, every request gets an error.

Only one request is outstanding at a time. A four-state machine runs it:
- IDLE accepts a request. It moves to RESP when the request is refused and to ISSUE when it is forwarded.
- ISSUE presents the request to the chosen set until that set accepts it, then moves to WAIT.
- WAIT takes the set's response and moves to RESP.
- RESP holds the upstream response until it is taken, then returns to IDLE.

Top module: `seg_firewall`

## Requirements
- R1: After reset the block is in IDLE. req_ready is 1, ms_valid is 00 and rsp_valid is 0.
- R2: A read to any segment is forwarded. ms_addr equals SET_BASE + segment index × 2^OFF_W + offset. With the default parameters this is 0x4000 + req_addr.
- R3: A write whose segment index (req_addr[AW-1:OFF_W]) equals OWN_ID is forwarded with ms_write=1 and ms_wdata equal to req_wdata.
- R4: A write to any other segment is not forwarded. ms_valid stays 00, and the cycle after acceptance rsp_valid=1 with rsp_err=1.
- R5: When set_fail is 00, a request goes to set 0 if req_addr[IL_BIT] is 0 and to set 1 if it is 1. Bit s of ms_valid addresses set s.
- R6: When exactly one set_fail bit is 1, every forwarded request goes to the other set.
- R7: When set_fail is 11, every request is answered with rsp_err=1 the cycle after acceptance, and nothing is forwarded.
- R8: The target set is fixed when the request is accepted. A change of set_fail while the request is outstanding does not move it. While ms_ready is low, ms_valid and ms_addr hold steady.
- R9: One request is outstanding at a time. req_ready is 0 from acceptance until the response handshake. rsp_valid rises the cycle after the set's response is taken and holds until rsp_ready.
- R10: The set's error flag and read data are returned unchanged on rsp_err and rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request accepted (IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Uniform address: segment index over offset |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_ready | input | 1 | Upstream response taken |
| rsp_err | output | 1 | 1 = error status, 0 = okay |
| rsp_rdata | output | DW | Read data |
| set_fail | input | 2 | Failed flag for each controller set |
| ms_valid | output | 2 | Request valid, one bit for each set |
| ms_ready | input | 2 | Set accepts the request |
| ms_write | output | 1 | Forwarded write flag |
| ms_addr | output | PAW | Set-local physical address |
| ms_wdata | output | DW | Forwarded write data |
| ms_rsp_valid | input | 2 | Set response valid |
| ms_rsp_ready | output | 2 | Response taken from a set |
| ms_rsp_err | input | 2 | Set response error flag |
| ms_rsp_rdata | input | 2*DW | Set read data, set s at bits [s*DW +: DW] |

## Verification
- **Refused requests:** a refused write, or any request made while both sets are flagged as failed, must show its error response on the first cycle after the accepting edge. The bench samples at the following falling edge and checks that ms_valid stayed 00.
- **Forwarded requests:** ms_valid is due on the first cycle after acceptance. It is checked on every cycle of a programmed stall until ms_ready is raised. The bench's controller model answers on the cycle after it accepts, so rsp_valid is due two edges after the set accepts.
- **Reference model:** for each transaction, the bench's per-cycle model lists the expected value of every output for each of these cycles and compares all of them at each falling edge. This includes req_ready held low until the response handshake.

// File: rtl/segfw_pkg.sv
package segfw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } fw_state_e;

    localparam int NUM_SETS = 2;
endpackage

// File: rtl/segfw_decode.sv
module segfw_decode #(
    parameter int NCOMP = 4,
    parameter int OFF_W = 10,
    parameter int OWN_ID = 2,
    parameter int PAW = 16,
    parameter logic [PAW-1:0] SET_BASE = 16'h4000,
    localparam int SEG_W = (NCOMP > 1) ? $clog2(NCOMP) : 1,
    localparam int AW = SEG_W + OFF_W
) (
    input  logic [AW-1:0]  addr,
    input  logic           write,
    output logic           denied,
    output logic [PAW-1:0] phys
);
    logic [SEG_W-1:0] seg_idx;
    logic [OFF_W-1:0] offset;

    always_comb begin
        seg_idx = addr[AW-1:OFF_W];
        offset  = addr[OFF_W-1:0];
        // writes only into the compartment's own segment
        denied  = write && (seg_idx != SEG_W'(OWN_ID));
        // set base + segment base + offset
        phys    = SET_BASE + (PAW'(seg_idx) << OFF_W) + PAW'(offset);
    end
endmodule

// File: rtl/segfw_route.sv
module segfw_route (
    input  logic       il_bit,
    input  logic [1:0] fail,
    output logic       sel,
    output logic       none_ok
);
    always_comb begin
        none_ok = &fail;
        unique case (fail)
            2'b00:   sel = il_bit;  // interleave across both sets
            2'b01:   sel = 1'b1;    // set 0 failed
            2'b10:   sel = 1'b0;    // set 1 failed
            default: sel = 1'b0;    // both failed, unused
        endcase
    end
endmodule

// File: rtl/segfw_ctrl.sv
module segfw_ctrl
    import segfw_pkg::*;
#(
    parameter int DW = 32,
    parameter int PAW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [DW-1:0]   req_wdata,
    input  logic            denied,
    input  logic [PAW-1:0]  phys,
    input  logic            sel,
    input  logic            none_ok,
    input  logic [1:0]      set_fail,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic [1:0]      ms_valid,
    input  logic [1:0]      ms_ready,
    output logic            ms_write,
    output logic [PAW-1:0]  ms_addr,
    output logic [DW-1:0]   ms_wdata,
    input  logic [1:0]      ms_rsp_valid,
    output logic [1:0]      ms_rsp_ready,
    input  logic [1:0]      ms_rsp_err,
    input  logic [2*DW-1:0] ms_rsp_rdata
);
    fw_state_e      st, st_nx;
    logic           tgt_q;
    logic           wr_q;
    logic [PAW-1:0] addr_q;
    logic [DW-1:0]  wd_q;
    logic           err_q;
    logic [DW-1:0]  rd_q;
    logic           accept;
    logic           refuse;
    logic [DW-1:0]  sel_rdata;

    assign accept    = (st == ST_IDLE) && req_valid;
    assign refuse    = denied || none_ok;
    assign sel_rdata = tgt_q ? ms_rsp_rdata[2*DW-1:DW] : ms_rsp_rdata[DW-1:0];

    // state register and request/response latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            tgt_q  <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            wd_q   <= '0;
            err_q  <= 1'b0;
            rd_q   <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                tgt_q  <= sel;
                wr_q   <= req_write;
                addr_q <= phys;
                wd_q   <= req_wdata;
                err_q  <= refuse;
                rd_q   <= '0;
            end
            if ((st == ST_WAIT) && ms_rsp_valid[tgt_q]) begin
                err_q <= ms_rsp_err[tgt_q];
                rd_q  <= sel_rdata;
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_nx = refuse ? ST_RESP : ST_ISSUE;
            ST_ISSUE: if (ms_ready[tgt_q]) st_nx = ST_WAIT;
            ST_WAIT:  if (ms_rsp_valid[tgt_q]) st_nx = ST_RESP;
            ST_RESP:  if (rsp_ready) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = (st == ST_IDLE);
        ms_valid     = (st == ST_ISSUE) ? (2'b01 << tgt_q) : 2'b00;
        ms_rsp_ready = (st == ST_WAIT) ? (2'b01 << tgt_q) : 2'b00;
        ms_write     = wr_q;
        ms_addr      = addr_q;
        ms_wdata     = wd_q;
        rsp_valid    = (st == ST_RESP);
        rsp_err      = err_q;
        rsp_rdata    = rd_q;
    end

    // R4 / R7: refused request answers with error next cycle, nothing issued
    a_r4_refused_errs: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && refuse) |=> (rsp_valid && rsp_err && ms_valid == 2'b00));

    a_r7_all_failed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (&set_fail)) |=> (rsp_valid && rsp_err));

    // R6: a forwarded request never targets a set flagged failed at acceptance
    a_r6_no_failed_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !refuse) |=> ((ms_valid & $past(set_fail)) == 2'b00));

    // R8: stalled request is held stable
    a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        ((ms_valid & ~ms_ready) != 2'b00) |=> ($stable(ms_valid) && $stable(ms_addr)));

    // R5: at most one set addressed
    a_r5_one_set: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ms_valid));

    // R9: no new request while a response is pending
    a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || ms_valid != 2'b00) |-> !req_ready);

    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
endmodule

// File: rtl/seg_firewall.sv
module seg_firewall #(
    parameter int NCOMP = 4,
    parameter int OFF_W = 10,
    parameter int OWN_ID = 2,
    parameter int DW = 32,
    parameter int PAW = 16,
    parameter logic [PAW-1:0] SET_BASE = 16'h4000,
    parameter int IL_BIT = 3,
    localparam int SEG_W = (NCOMP > 1) ? $clog2(NCOMP) : 1,
    localparam int AW = SEG_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    input  logic [1:0]      set_fail,
    output logic [1:0]      ms_valid,
    input  logic [1:0]      ms_ready,
    output logic            ms_write,
    output logic [PAW-1:0]  ms_addr,
    output logic [DW-1:0]   ms_wdata,
    input  logic [1:0]      ms_rsp_valid,
    output logic [1:0]      ms_rsp_ready,
    input  logic [1:0]      ms_rsp_err,
    input  logic [2*DW-1:0] ms_rsp_rdata
);
    logic           denied;
    logic [PAW-1:0] phys;
    logic           sel;
    logic           none_ok;

    segfw_decode #(
        .NCOMP(NCOMP), .OFF_W(OFF_W), .OWN_ID(OWN_ID),
        .PAW(PAW), .SET_BASE(SET_BASE)
    ) u_decode (
        .addr(req_addr), .write(req_write), .denied(denied), .phys(phys)
    );

    segfw_route u_route (
        .il_bit(req_addr[IL_BIT]), .fail(set_fail), .sel(sel), .none_ok(none_ok)
    );

    segfw_ctrl #(.DW(DW), .PAW(PAW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wdata(req_wdata),
        .denied(denied), .phys(phys), .sel(sel), .none_ok(none_ok),
        .set_fail(set_fail),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ms_valid(ms_valid), .ms_ready(ms_ready),
        .ms_write(ms_write), .ms_addr(ms_addr), .ms_wdata(ms_wdata),
        .ms_rsp_valid(ms_rsp_valid), .ms_rsp_ready(ms_rsp_ready),
        .ms_rsp_err(ms_rsp_err), .ms_rsp_rdata(ms_rsp_rdata)
    );
endmodule

// File: tb/test_seg_firewall.sv
module test_seg_firewall;
    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [1:0]  set_fail = 2'b00;
    logic [1:0]  ms_valid;
    logic [1:0]  rdy = 2'b11;
    logic        ms_write;
    logic [15:0] ms_addr;
    logic [31:0] ms_wdata;
    logic [1:0]  mrv = 2'b00;
    logic [1:0]  ms_rsp_ready;
    logic        ctl_err = 1'b0;
    logic [63:0] mrd = '0;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_firewall i_seg_firewall (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .set_fail(set_fail),
        .ms_valid(ms_valid), .ms_ready(rdy),
        .ms_write(ms_write), .ms_addr(ms_addr), .ms_wdata(ms_wdata),
        .ms_rsp_valid(mrv), .ms_rsp_ready(ms_rsp_ready),
        .ms_rsp_err({ctl_err, ctl_err}), .ms_rsp_rdata(mrd)
    );

    function automatic logic [31:0] ctl_data(input int s, input logic [15:0] pa);
        return {(s == 1) ? 8'hB1 : 8'hA0, 8'h00, pa};
    endfunction

    // controller-set model: answers the cycle after accepting
    always @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (!rst_n) begin
                mrv[s] <= 1'b0;
            end else if (ms_valid[s] && rdy[s]) begin
                mrv[s] <= 1'b1;
                mrd[s*DW +: DW] <= ctl_data(s, ms_addr);
            end else if (mrv[s] && ms_rsp_ready[s]) begin
                mrv[s] <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // per-cycle reference model of one transaction
    task automatic run(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                       input bit exp_err, input int es, input int stall,
                       input bit flip, input int hold, input string rq);
        logic [15:0] pa;
        logic [1:0]  ev;
        pa = 16'h4000 + {4'h0, a};
        ev = 2'b01 << es;
        @(negedge clk);
        chk(req_ready == 1'b1, {rq, " idle ready"}, 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        rdy = (stall == 0) ? 2'b11 : 2'b00;
        rsp_ready = (hold == 0);
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_err) begin
            for (int i = 0; i <= stall; i++) begin
                chk(ms_valid == ev, {rq, " target set"}, 64'(ms_valid), 64'(ev));
                chk(ms_addr == pa, {rq, " phys addr"}, 64'(ms_addr), 64'(pa));
                chk(ms_write == wr, {rq, " write flag"}, 64'(ms_write), 64'(wr));
                if (wr) chk(ms_wdata == wd, {rq, " wdata"}, 64'(ms_wdata), 64'(wd));
                chk(req_ready == 1'b0, "R9 busy during issue", 64'(req_ready), 64'd0);
                chk(rsp_valid == 1'b0, {rq, " no early rsp"}, 64'(rsp_valid), 64'd0);
                if (flip && i == 0) set_fail = set_fail | ev;
                if (i == stall) rdy = 2'b11;
                @(negedge clk);
            end
            chk(ms_valid == 2'b00, {rq, " issue dropped"}, 64'(ms_valid), 64'd0);
            chk(rsp_valid == 1'b0, "R9 wait cycle", 64'(rsp_valid), 64'd0);
            chk(req_ready == 1'b0, "R9 busy during wait", 64'(req_ready), 64'd0);
            @(negedge clk);
        end
        for (int j = 0; j <= hold; j++) begin
            chk(rsp_valid == 1'b1, {rq, " rsp valid"}, 64'(rsp_valid), 64'd1);
            chk(rsp_err == (exp_err | ctl_err), {rq, " rsp err"}, 64'(rsp_err), 64'(exp_err | ctl_err));
            if (!exp_err)
                chk(rsp_rdata == ctl_data(es, pa), {rq, " rdata"}, 64'(rsp_rdata), 64'(ctl_data(es, pa)));
            chk(ms_valid == 2'b00, {rq, " nothing forwarded"}, 64'(ms_valid), 64'd0);
            chk(req_ready == 1'b0, "R9 busy during rsp", 64'(req_ready), 64'd0);
            if (j == hold) rsp_ready = 1'b1;
            @(negedge clk);
        end
        chk(rsp_valid == 1'b0, {rq, " rsp done"}, 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R9 ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        chk(ms_valid == 2'b00, "R1 ms_valid", 64'(ms_valid), 64'd0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);

        // R2 reads to own and foreign segments; R5 interleave bit 3
        run(1'b0, 12'h800, 32'h0, 1'b0, 0, 0, 1'b0, 0, "R2 read own seg");
        run(1'b0, 12'h0C8, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R2 read seg0");
        run(1'b0, 12'hFF8, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R2 read seg3 top");
        run(1'b0, 12'h300, 32'h0, 1'b0, 0, 0, 1'b0, 0, "R5 bit3=0 set0");
        run(1'b0, 12'h308, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R5 bit3=1 set1");

        // R3 own-segment writes
        run(1'b1, 12'h9A0, 32'hDEADBEEF, 1'b0, 0, 0, 1'b0, 0, "R3 write own");
        run(1'b1, 12'hBF8, 32'h12345678, 1'b0, 1, 0, 1'b0, 0, "R3 write own top");

        // R4 foreign writes refused
        run(1'b1, 12'hC10, 32'h1, 1'b1, 0, 0, 1'b0, 0, "R4 write seg3");
        run(1'b1, 12'h010, 32'h2, 1'b1, 0, 0, 1'b0, 1, "R4 write seg0");
        run(1'b1, 12'h7FF, 32'h3, 1'b1, 0, 0, 1'b0, 0, "R4 write seg1 edge");

        // R6 single-set failover
        set_fail = 2'b01;
        run(1'b0, 12'h300, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R6 set0 failed");
        set_fail = 2'b10;
        run(1'b0, 12'h308, 32'h0, 1'b0, 0, 0, 1'b0, 0, "R6 set1 failed");
        run(1'b1, 12'h808, 32'hA5A5, 1'b0, 0, 0, 1'b0, 0, "R6 write survivor");

        // R7 both failed
        set_fail = 2'b11;
        run(1'b0, 12'h100, 32'h0, 1'b1, 0, 0, 1'b0, 0, "R7 read both failed");
        run(1'b1, 12'h900, 32'h5, 1'b1, 0, 0, 1'b0, 0, "R7 write both failed");

        // R8 fail flag change while outstanding, with stall
        set_fail = 2'b00;
        run(1'b0, 12'h300, 32'h0, 1'b0, 0, 3, 1'b1, 0, "R8 in-flight keeps set0");
        run(1'b0, 12'h300, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R8 later req moves");
        set_fail = 2'b00;
        run(1'b1, 12'h808, 32'h77, 1'b0, 1, 2, 1'b1, 0, "R8 in-flight keeps set1");
        set_fail = 2'b00;

        // R9 response backpressure
        run(1'b0, 12'h040, 32'h0, 1'b0, 0, 1, 1'b0, 3, "R9 rsp hold");

        // R10 controller error and data passthrough
        ctl_err = 1'b1;
        run(1'b0, 12'h448, 32'h0, 1'b0, 1, 0, 1'b0, 0, "R10 ctl err");
        ctl_err = 1'b0;
        run(1'b0, 12'h440, 32'h0, 1'b0, 0, 0, 1'b0, 0, "R10 ctl ok");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule